// File: doc/BRIEF.md
# Loadable Up Counter with Load-Plus-One Mode

This block is a parameterised up counter built as a state register fed by a combinational incrementer and a load multiplexer. On each rising clock edge it can hold, count up by one, take a parallel value, or take that parallel value plus one. The last of these applies when the load strobe and the count enable are both high in the same cycle. Increment and load-plus-one wrap modulo 2^WIDTH and produce no carry.

Two clears are provided. The asynchronous clear forces the count to zero as soon as it goes high. Its release passes through a short synchronizer, so the register leaves reset on a clock edge. The synchronous clear zeroes the count on the next rising edge and wins over load and enable.

A typical use is an address or iteration counter in a datapath. A controller either preloads it or preloads it one step ahead, and then steps it with the enable.

Top module: `ldcnt_top`

## Requirements
- R1: While `aclr` is high the count is zero at once, without waiting for a clock edge and whatever `load`, `cnt_en`, `sclr` and `din` are doing.
- R2: After `aclr` falls, the count stays zero through the next SYNC_STAGES (default 2) rising edges whatever the other inputs are. The first operation takes effect on the edge after those.
- R3: `sclr` high on a rising edge makes the count zero, overriding `load` and `cnt_en`.
- R4: `load`=1, `cnt_en`=0 on an edge makes the count equal to `din`.
- R5: `load`=0, `cnt_en`=1 on an edge adds one to the count.
- R6: `load`=1, `cnt_en`=1 on an edge makes the count equal to `din` plus one.
- R7: `load`=0, `cnt_en`=0 on an edge leaves the count unchanged.
- R8: Arithmetic wraps modulo 2^WIDTH with no carry out. Incrementing all-ones gives zero, and load-plus-one of all-ones gives zero.
- R9: Loading 0xA0 and then incrementing twice gives the sequence 0xA0, 0xA1, 0xA2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| aclr | input | 1 | Asynchronous clear, active high, released through a synchronizer |
| sclr | input | 1 | Synchronous clear, active high, highest priority on an edge |
| load | input | 1 | Parallel load strobe |
| cnt_en | input | 1 | Count enable; together with `load` it selects load-plus-one |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |

## Verification
Every `din` value is loaded both plainly and with the enable high. Comparing the two results shows whether the multiplexer or the incrementer is at fault. Long runs of increments cross 0xFF and confirm the wrap. Runs where `sclr` is high alongside each load/enable pair show that the clear takes priority. Sequences that mix hold cycles between operations separate hold from increment. The asynchronous clear is raised in the middle of a cycle with load and enable high, and is then released, so the immediate zero and the two-edge release delay are each observed.

// File: rtl/ldcnt_pkg.sv
// Package: shared operation encoding for the loadable counter.
// Assumes: consumers decode only the four values below.
package ldcnt_pkg;

    // Operation chosen for a clock edge once the clears are out of the way.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_INC   = 2'b01,
        OP_LOAD  = 2'b10,
        OP_LDINC = 2'b11
    } cnt_op_e;

    // Builds the operation from the load strobe and the count enable.
    function automatic cnt_op_e pick_op(input logic ld, input logic en);
        return cnt_op_e'({ld, en});
    endfunction

endpackage

// File: rtl/ldcnt_incr.sv
// Module: combinational conditional incrementer.
// Output is the input plus one when inc is high and the input unchanged
// otherwise. It wraps modulo 2^WIDTH and has no carry out.
// Assumes: WIDTH >= 1.
module ldcnt_incr #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             inc,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Adds one only when requested.
    always_comb begin
        y = inc ? (a + ONE) : a;
    end
endmodule

// File: rtl/ldcnt_clrsync.sv
// Module: clear synchronizer. The input sets the hold output at once and
// asynchronously. The hold output falls only after STAGES rising edges with
// the input low.
// Assumes: STAGES >= 1 and the input is active high.
module ldcnt_clrsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_in,
    output logic clr_hold
);
    logic [STAGES-1:0] chain;

    // Shifts zeros in after release; the clear input fills the chain with ones.
    always_ff @(posedge clk or posedge clr_in) begin
        if (clr_in) chain <= '1;
        else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], 1'b0} & {STAGES{STAGES > 1}};
    end

    // The oldest stage drives the hold output.
    assign clr_hold = chain[STAGES-1];
endmodule

// File: rtl/ldcnt_top.sv
// Module: loadable up counter with a load-plus-one mode.
// On each rising edge the priority order is: the asynchronous clear hold,
// then sclr, then the load/enable operation.
//   load=0 en=0 : hold       load=0 en=1 : count+1
//   load=1 en=0 : din        load=1 en=1 : din+1
// Assumes: the inputs other than aclr are synchronous to clk. aclr may
// arrive at any time.
module ldcnt_top #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             sclr,
    input  logic             load,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);
    import ldcnt_pkg::*;

    logic             clr_hold;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_inc;
    logic [WIDTH-1:0] din_inc;
    logic [WIDTH-1:0] q_nxt;
    cnt_op_e          op;

    ldcnt_clrsync #(.STAGES(SYNC_STAGES)) u_clrsync (
        .clk      (clk),
        .clr_in   (aclr),
        .clr_hold (clr_hold)
    );

    // Incrementer on the register path.
    ldcnt_incr #(.WIDTH(WIDTH)) u_inc_q (
        .a   (q_r),
        .inc (cnt_en),
        .y   (q_inc)
    );

    // Incrementer on the parallel-input path.
    ldcnt_incr #(.WIDTH(WIDTH)) u_inc_d (
        .a   (din),
        .inc (cnt_en),
        .y   (din_inc)
    );

    // Load multiplexer, with the synchronous clear in front of it.
    always_comb begin
        op = pick_op(load, cnt_en);
        unique case (op)
            OP_LOAD, OP_LDINC: q_nxt = din_inc;
            default:           q_nxt = q_inc;
        endcase
        if (sclr) q_nxt = '0;
    end

    // Count register, cleared while the clear hold is active.
    always_ff @(posedge clk or posedge clr_hold) begin
        if (clr_hold) q_r <= '0;
        else          q_r <= q_nxt;
    end

    assign count = q_r;
endmodule

// File: rtl/ldcnt_chk.sv
// Module: assertion checker for ldcnt_top, attached through bind.
// Assumes: clr_hold is the counter's internal clear hold.
module ldcnt_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             aclr,
    input logic             clr_hold,
    input logic             sclr,
    input logic             load,
    input logic             cnt_en,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    AST_ACLR_ZERO:  assert property (@(posedge clk) aclr |-> count == '0); // R1
    AST_RELEASE_ZERO: assert property (@(posedge clk) $past(clr_hold) |-> count == '0); // R2
    AST_SCLR_WINS:  assert property (@(posedge clk) disable iff (clr_hold)
                        (!clr_hold && sclr) |=> count == '0); // R3
    AST_LOAD_DIN:   assert property (@(posedge clk) disable iff (clr_hold)
                        (!clr_hold && !sclr && load && !cnt_en) |=> count == $past(din)); // R4
    AST_INC_ONE:    assert property (@(posedge clk) disable iff (clr_hold)
                        (!clr_hold && !sclr && !load && cnt_en) |=> count == $past(count) + ONE); // R5
    AST_LOAD_PLUS:  assert property (@(posedge clk) disable iff (clr_hold)
                        (!clr_hold && !sclr && load && cnt_en) |=> count == $past(din) + ONE); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr_hold)
                        (!clr_hold && !sclr && !load && !cnt_en) |=> $stable(count)); // R7
endmodule

bind ldcnt_top ldcnt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .aclr     (aclr),
    .clr_hold (clr_hold),
    .sclr     (sclr),
    .load     (load),
    .cnt_en   (cnt_en),
    .din      (din),
    .count    (count)
);

// File: tb/ldcnt_top_tb.sv
// Bench: near-exhaustive sweep of ldcnt_top at WIDTH=8 against an
// arithmetic model of the counter.
module ldcnt_top_tb;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int SYNC   = 2;
    localparam int MODV   = 1 << W;

    logic         clk = 1'b0;
    logic         aclr = 1'b1;
    logic         sclr = 1'b0;
    logic         load = 1'b0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;

    int n_vec  = 0;
    int n_fail = 0;
    int model  = 0;
    int rel_left = 0;

    ldcnt_top #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut (
        .clk    (clk),
        .aclr   (aclr),
        .sclr   (sclr),
        .load   (load),
        .cnt_en (cnt_en),
        .din    (din),
        .count  (count)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int exp);
        n_vec++;
        if (int'(count) != exp) begin
            n_fail++;
            $display("FAIL %s: count=%02h expected=%02h", tag, count, exp[W-1:0]);
        end
    endtask

    // Drives one operation at the falling edge, passes a rising edge,
    // updates the model and compares at the next falling edge.
    task automatic step(input string tag, input bit s, input bit l, input bit e, input int d);
        sclr = s; load = l; cnt_en = e; din = W'(d);
        @(posedge clk);
        if (aclr) model = 0;
        else if (rel_left > 0) begin rel_left--; model = 0; end
        else if (s) model = 0;
        else if (l) model = (d + (e ? 1 : 0)) % MODV;
        else model = (model + (e ? 1 : 0)) % MODV;
        @(negedge clk);
        check(tag, model);
    endtask

    task automatic release_clear();
        aclr = 1'b0;
        rel_left = SYNC;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: count=%02h expected=%02h", count, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 reset", 0);
        release_clear();
        // R2: operations ignored for two edges after release
        step("R2 rel1", 0, 1, 1, 8'h55);
        step("R2 rel2", 0, 1, 0, 8'h66);
        step("R2 first", 0, 1, 0, 8'h77);
        // R9: load A0 then two increments
        step("R9 load", 0, 1, 0, 8'hA0);
        step("R9 inc1", 0, 0, 1, 8'h00);
        step("R9 inc2", 0, 0, 1, 8'h00);
        // R4 and R6: every din value, plain and plus one
        for (int d = 0; d < MODV; d++) begin
            step("R4 load", 0, 1, 0, d);
            step("R6 ldinc", 0, 1, 1, d);
            step("R7 hold", 0, 0, 0, (d * 37) % MODV);
        end
        // R5 and R8: a full trip around plus a bit, crossing FF->00
        step("R4 preload", 0, 1, 0, 8'hF0);
        for (int i = 0; i < MODV + 20; i++) step("R5 R8 inc", 0, 0, 1, i % MODV);
        step("R8 ldinc FF", 0, 1, 1, 8'hFF);
        // R3: sclr beats each load/enable pair
        for (int c = 0; c < 4; c++) begin
            step("R4 pre", 0, 1, 0, 8'h3C + c);
            step("R3 sclr", 1, c[1], c[0], 8'hC3);
        end
        // R7: hold streak
        step("R4 pre", 0, 1, 0, 8'h9A);
        for (int i = 0; i < 5; i++) step("R7 hold", 0, 0, 0, 8'h11 * i);
        // R1: mid-cycle clear with load and enable active
        sclr = 0; load = 1; cnt_en = 1; din = 8'h44;
        #(PERIOD/4);
        aclr = 1'b1;
        #1;
        check("R1 immediate", 0);
        @(negedge clk);
        check("R1 held", 0);
        release_clear();
        step("R2 rel1b", 0, 0, 1, 0);
        step("R2 rel2b", 0, 1, 1, 8'h10);
        step("R2 firstb", 0, 1, 1, 8'h10);
        step("R5 after", 0, 0, 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule